// File: doc/BRIEF.md
# Execute-Stage Operand and Writeback Control

This block sits in the execute stage of a 32-bit five-stage integer pipeline. It receives the control flags the decode stage produced (immediate-operand select, destination select, register write, memory read and memory write), the opcode and function fields, the target and destination register indices, the shift amount, the 16-bit immediate and the two register operand values. From these it chooses the ALU operation, builds the ALU second operand, picks the destination register and settles the final register-write enable. A small integer ALU is included so that the effective-address and arithmetic results can be seen at the ports.

The ALU operation comes straight from the function field for register-format instructions (opcode 0). For every other opcode it comes from a fixed per-opcode table. Opcodes missing from that table raise an illegal-instruction flag, and every side effect of that instruction is blocked. Conditional moves are resolved here: the register write is dropped when the move condition on the target operand fails.

The block is purely combinational and has no clock. Its operands are control and data words of the current instruction, with no stream between stages, so there is no valid/ready handshake. All outputs follow the inputs within the same cycle.

Top module: `exe_ctl_top`

## Requirements
- R1: When opcode is 0, `alu_op_o` equals `funct_i`, and the opcode table is not used.
- R2: The immediate opcodes map to ALU codes (function-field encoding): 8 to add (32), 9 to add-unsigned (33), 10 to set-less-than (42), 11 to set-less-than-unsigned (43), 12 to and (36), 13 to or (37), 14 to xor (38).
- R3: Load opcodes 32, 33, 35, 36 and 37 and store opcodes 40, 41 and 43 select add (32), so `alu_y_o` is the rs value plus the sign-extended immediate.
- R4: With `alusrc_i` high, `alu_b_o` is `imm_i` with bit 15 copied into bits 31..16. With `alusrc_i` low, it is `rt_val_i`.
- R5: `dest_idx_o` is `rd_idx_i` when `regd_i` is high and `rt_idx_i` otherwise.
- R6: For opcode 0 with funct 10 (move-if-zero), `reg_we_o` is low whenever `rt_val_i` is nonzero. When `rt_val_i` is zero it follows `regwrite_i`, and `alu_y_o` equals the rs value.
- R7: For opcode 0 with funct 11 (move-if-nonzero), `reg_we_o` is low whenever `rt_val_i` is zero. When `rt_val_i` is nonzero it follows `regwrite_i`, and `alu_y_o` equals the rs value.
- R8: Opcodes 3, 15, 16 to 31, 34, 38, 39, 42 and 44 to 63 are unsupported. For these, `illegal_o` is high and `reg_we_o`, `mem_re_o` and `mem_we_o` are low whatever the flags say. Branch and jump opcodes 1, 2 and 4 to 7 are legal and select code 0.
- R9: For supported opcodes, `mem_re_o` and `mem_we_o` follow `memread_i` and `memwrite_i`, and `illegal_o` is low.
- R10: The ALU computes the following. Code 0 gives b<<shamt, 2 gives b>>shamt, 3 gives arithmetic b>>shamt, 32 and 33 give a+b, and 34 and 35 give a-b. Codes 36, 37, 38 and 39 give and, or, xor and nor. Code 42 gives 1 when a<b signed and 43 gives 1 when a<b unsigned, 0 otherwise. Any other code gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 6 | Primary opcode |
| funct_i | input | 6 | Function field of register-format instructions |
| rt_idx_i | input | 5 | Target register index |
| rd_idx_i | input | 5 | Destination register index field |
| shamt_i | input | 5 | Shift amount field |
| imm_i | input | 16 | Immediate field |
| rs_val_i | input | 32 | First operand value |
| rt_val_i | input | 32 | Second register operand value |
| alusrc_i | input | 1 | Use the immediate as second operand |
| regd_i | input | 1 | Destination comes from the rd field |
| regwrite_i | input | 1 | Decoded register-write request |
| memread_i | input | 1 | Decoded memory-read request |
| memwrite_i | input | 1 | Decoded memory-write request |
| alu_op_o | output | 6 | Selected ALU operation code |
| alu_b_o | output | 32 | ALU second operand |
| alu_y_o | output | 32 | ALU result |
| dest_idx_o | output | 5 | Destination register index |
| reg_we_o | output | 1 | Final register-write enable |
| mem_re_o | output | 1 | Gated memory-read request |
| mem_we_o | output | 1 | Gated memory-write request |
| illegal_o | output | 1 | Opcode has no table entry |

## Verification
Every result is due in the same cycle as its stimulus, because no register lies between the inputs and any output. The bench changes inputs on the falling clock edge and compares outputs one nanosecond later, well before the next rising edge. No check waits a cycle, and no check is taken while inputs are changing.

// File: rtl/exe_ctl_pkg.sv
package exe_ctl_pkg;
  localparam int OP_W = 6;

  localparam logic [OP_W-1:0] ALU_SLL  = 6'd0;
  localparam logic [OP_W-1:0] ALU_SRL  = 6'd2;
  localparam logic [OP_W-1:0] ALU_SRA  = 6'd3;
  localparam logic [OP_W-1:0] ALU_MVZ  = 6'd10;
  localparam logic [OP_W-1:0] ALU_MVN  = 6'd11;
  localparam logic [OP_W-1:0] ALU_ADD  = 6'd32;
  localparam logic [OP_W-1:0] ALU_ADDU = 6'd33;
  localparam logic [OP_W-1:0] ALU_SUB  = 6'd34;
  localparam logic [OP_W-1:0] ALU_SUBU = 6'd35;
  localparam logic [OP_W-1:0] ALU_AND  = 6'd36;
  localparam logic [OP_W-1:0] ALU_OR   = 6'd37;
  localparam logic [OP_W-1:0] ALU_XOR  = 6'd38;
  localparam logic [OP_W-1:0] ALU_NOR  = 6'd39;
  localparam logic [OP_W-1:0] ALU_SLT  = 6'd42;
  localparam logic [OP_W-1:0] ALU_SLTU = 6'd43;

  typedef struct packed {
    logic            known;
    logic [OP_W-1:0] op;
  } op_entry_t;
endpackage

// File: rtl/exe_op_table.sv
module exe_op_table
  import exe_ctl_pkg::*;
(
  input  logic [OP_W-1:0] opcode_i,
  output op_entry_t       entry_o
);
  always_comb begin
    entry_o = '{known: 1'b0, op: ALU_SLL};
    unique case (opcode_i)
      6'd0, 6'd1, 6'd2, 6'd4, 6'd5, 6'd6, 6'd7:
        entry_o = '{known: 1'b1, op: ALU_SLL};
      6'd8:  entry_o = '{known: 1'b1, op: ALU_ADD};
      6'd9:  entry_o = '{known: 1'b1, op: ALU_ADDU};
      6'd10: entry_o = '{known: 1'b1, op: ALU_SLT};
      6'd11: entry_o = '{known: 1'b1, op: ALU_SLTU};
      6'd12: entry_o = '{known: 1'b1, op: ALU_AND};
      6'd13: entry_o = '{known: 1'b1, op: ALU_OR};
      6'd14: entry_o = '{known: 1'b1, op: ALU_XOR};
      6'd32, 6'd33, 6'd35, 6'd36, 6'd37, 6'd40, 6'd41, 6'd43:
        entry_o = '{known: 1'b1, op: ALU_ADD};
      default: entry_o = '{known: 1'b0, op: ALU_SLL};
    endcase
  end
endmodule

// File: rtl/exe_operand_sel.sv
module exe_operand_sel #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int IDX_W  = 5
) (
  input  logic              alusrc_i,
  input  logic              regd_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [DATA_W-1:0] rt_val_i,
  input  logic [IDX_W-1:0]  rt_idx_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] b_o,
  output logic [IDX_W-1:0]  dest_o
);
  localparam int EXT_W = DATA_W - IMM_W;
  logic [DATA_W-1:0] imm_ext;

  generate
    if (EXT_W > 0) begin : g_ext
      assign imm_ext = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
    end else begin : g_trunc
      assign imm_ext = imm_i[DATA_W-1:0];
    end
  endgenerate

  assign b_o    = alusrc_i ? imm_ext : rt_val_i;
  assign dest_o = regd_i ? rd_idx_i : rt_idx_i;
endmodule

// File: rtl/exe_alu.sv
module exe_alu
  import exe_ctl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SH_W   = 5
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [SH_W-1:0]   shamt_i,
  output logic [DATA_W-1:0] y_o
);
  always_comb begin
    unique case (op_i)
      ALU_SLL:            y_o = b_i << shamt_i;
      ALU_SRL:            y_o = b_i >> shamt_i;
      ALU_SRA:            y_o = $unsigned($signed(b_i) >>> shamt_i);
      ALU_MVZ, ALU_MVN:   y_o = a_i;
      ALU_ADD, ALU_ADDU:  y_o = a_i + b_i;
      ALU_SUB, ALU_SUBU:  y_o = a_i - b_i;
      ALU_AND:            y_o = a_i & b_i;
      ALU_OR:             y_o = a_i | b_i;
      ALU_XOR:            y_o = a_i ^ b_i;
      ALU_NOR:            y_o = ~(a_i | b_i);
      ALU_SLT:            y_o = {{(DATA_W-1){1'b0}}, $signed(a_i) < $signed(b_i)};
      ALU_SLTU:           y_o = {{(DATA_W-1){1'b0}}, a_i < b_i};
      default:            y_o = '0;
    endcase
  end
endmodule

// File: rtl/exe_ctl_top.sv
module exe_ctl_top
  import exe_ctl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int IDX_W  = 5
) (
  input  logic [5:0]        opcode_i,
  input  logic [5:0]        funct_i,
  input  logic [IDX_W-1:0]  rt_idx_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [IDX_W-1:0]  shamt_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [DATA_W-1:0] rs_val_i,
  input  logic [DATA_W-1:0] rt_val_i,
  input  logic              alusrc_i,
  input  logic              regd_i,
  input  logic              regwrite_i,
  input  logic              memread_i,
  input  logic              memwrite_i,
  output logic [5:0]        alu_op_o,
  output logic [DATA_W-1:0] alu_b_o,
  output logic [DATA_W-1:0] alu_y_o,
  output logic [IDX_W-1:0]  dest_idx_o,
  output logic              reg_we_o,
  output logic              mem_re_o,
  output logic              mem_we_o,
  output logic              illegal_o
);
  op_entry_t entry;
  logic      is_rtype;
  logic      rt_zero;
  logic      move_blocked;

  exe_op_table u_table (
    .opcode_i (opcode_i),
    .entry_o  (entry)
  );

  exe_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W), .IDX_W(IDX_W)) u_sel (
    .alusrc_i (alusrc_i),
    .regd_i   (regd_i),
    .imm_i    (imm_i),
    .rt_val_i (rt_val_i),
    .rt_idx_i (rt_idx_i),
    .rd_idx_i (rd_idx_i),
    .b_o      (alu_b_o),
    .dest_o   (dest_idx_o)
  );

  assign is_rtype = (opcode_i == '0);
  assign alu_op_o = is_rtype ? funct_i : entry.op;
  assign rt_zero  = (rt_val_i == '0);

  always_comb begin
    move_blocked = 1'b0;
    if (is_rtype && funct_i == ALU_MVZ && !rt_zero) move_blocked = 1'b1;
    if (is_rtype && funct_i == ALU_MVN &&  rt_zero) move_blocked = 1'b1;
  end

  assign illegal_o = !entry.known;
  assign reg_we_o  = regwrite_i && entry.known && !move_blocked;
  assign mem_re_o  = memread_i  && entry.known;
  assign mem_we_o  = memwrite_i && entry.known;

  exe_alu #(.DATA_W(DATA_W), .SH_W(IDX_W)) u_alu (
    .op_i    (alu_op_o),
    .a_i     (rs_val_i),
    .b_i     (alu_b_o),
    .shamt_i (shamt_i),
    .y_o     (alu_y_o)
  );

  always_comb begin
    a_r1_rtype_funct: assert (!is_rtype || alu_op_o == funct_i);
    a_r3_mem_uses_add: assert (!(opcode_i[5] && !illegal_o) || alu_op_o == ALU_ADD);
    a_r6_movz_blocks: assert (!(is_rtype && funct_i == ALU_MVZ && rt_val_i != '0) || !reg_we_o);
    a_r7_movn_blocks: assert (!(is_rtype && funct_i == ALU_MVN && rt_val_i == '0) || !reg_we_o);
    a_r8_illegal_quiet: assert (!illegal_o || !(reg_we_o || mem_re_o || mem_we_o));
  end
endmodule

// File: tb/tb_exe_ctl_top.sv
module tb_exe_ctl_top;
  logic        clk = 1'b0;
  always #2 clk = ~clk;

  logic [5:0]  opcode, funct;
  logic [4:0]  rt_idx, rd_idx, shamt;
  logic [15:0] imm;
  logic [31:0] rs_val, rt_val;
  logic        alusrc, regd, regwrite, memread, memwrite;
  logic [5:0]  alu_op;
  logic [31:0] alu_b, alu_y;
  logic [4:0]  dest_idx;
  logic        reg_we, mem_re, mem_we, illegal;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  exe_ctl_top dut (
    .opcode_i(opcode), .funct_i(funct), .rt_idx_i(rt_idx), .rd_idx_i(rd_idx),
    .shamt_i(shamt), .imm_i(imm), .rs_val_i(rs_val), .rt_val_i(rt_val),
    .alusrc_i(alusrc), .regd_i(regd), .regwrite_i(regwrite),
    .memread_i(memread), .memwrite_i(memwrite),
    .alu_op_o(alu_op), .alu_b_o(alu_b), .alu_y_o(alu_y), .dest_idx_o(dest_idx),
    .reg_we_o(reg_we), .mem_re_o(mem_re), .mem_we_o(mem_we), .illegal_o(illegal)
  );

  // {opcode, expected alu op, expected illegal}
  localparam int NV = 33;
  localparam logic [12:0] VEC [NV] = '{
    {6'd1, 6'd0, 1'b0},  {6'd2, 6'd0, 1'b0},  {6'd3, 6'd0, 1'b1},
    {6'd4, 6'd0, 1'b0},  {6'd5, 6'd0, 1'b0},  {6'd6, 6'd0, 1'b0},
    {6'd7, 6'd0, 1'b0},  {6'd8, 6'd32, 1'b0}, {6'd9, 6'd33, 1'b0},
    {6'd10, 6'd42, 1'b0}, {6'd11, 6'd43, 1'b0}, {6'd12, 6'd36, 1'b0},
    {6'd13, 6'd37, 1'b0}, {6'd14, 6'd38, 1'b0}, {6'd15, 6'd0, 1'b1},
    {6'd16, 6'd0, 1'b1}, {6'd31, 6'd0, 1'b1}, {6'd32, 6'd32, 1'b0},
    {6'd33, 6'd32, 1'b0}, {6'd34, 6'd0, 1'b1}, {6'd35, 6'd32, 1'b0},
    {6'd36, 6'd32, 1'b0}, {6'd37, 6'd32, 1'b0}, {6'd38, 6'd0, 1'b1},
    {6'd39, 6'd0, 1'b1}, {6'd40, 6'd32, 1'b0}, {6'd41, 6'd32, 1'b0},
    {6'd42, 6'd0, 1'b1}, {6'd43, 6'd32, 1'b0}, {6'd44, 6'd0, 1'b1},
    {6'd46, 6'd0, 1'b1}, {6'd50, 6'd0, 1'b1}, {6'd63, 6'd0, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [5:0] op, input logic [5:0] fn,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] im, input logic [4:0] sh,
                       input logic src, input logic rdsel, input logic rw,
                       input logic mr, input logic mw);
    @(negedge clk);
    opcode = op; funct = fn; rs_val = a; rt_val = b; imm = im; shamt = sh;
    alusrc = src; regd = rdsel; regwrite = rw; memread = mr; memwrite = mw;
    rt_idx = 5'd7; rd_idx = 5'd19;
    #1;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // Idle state: all-zero inputs are a legal shift by zero with no write
    drive(6'd0, 6'd0, 32'd0, 32'd0, 16'd0, 5'd0, 0, 0, 0, 0, 0);
    chk("R9 idle illegal", {31'd0, illegal}, 32'd0);
    chk("R9 idle reg_we", {31'd0, reg_we}, 32'd0);

    // Opcode table walk; funct holds subtract to show it is ignored (R2 R3 R8)
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][12:7], 6'd34, 32'd1, 32'd2, 16'd4, 5'd0, 1, 0, 1, 1, 1);
      chk("R2/R3/R8 table op", {26'd0, alu_op}, {26'd0, VEC[i][6:1]});
      chk("R8 illegal flag", {31'd0, illegal}, {31'd0, VEC[i][0]});
      chk("R8/R9 gated flags", {29'd0, reg_we, mem_re, mem_we},
          VEC[i][0] ? 32'd0 : 32'd7);
    end

    // R3 load address with negative offset
    drive(6'd35, 6'd0, 32'h1000, 32'h0, 16'hFFFC, 5'd0, 1, 0, 1, 1, 0);
    chk("R3 load addr", alu_y, 32'h0000_0FFC);
    chk("R4 sext negative", alu_b, 32'hFFFF_FFFC);
    chk("R5 dest rt", {27'd0, dest_idx}, 32'd7);
    chk("R9 memread pass", {30'd0, mem_re, mem_we}, 32'd2);
    // R3 store
    drive(6'd43, 6'd0, 32'h2000, 32'h55, 16'h0010, 5'd0, 1, 0, 0, 0, 1);
    chk("R3 store addr", alu_y, 32'h2010);
    chk("R9 store flags", {29'd0, reg_we, mem_re, mem_we}, 32'd1);
    // R2 immediates
    drive(6'd8, 6'd0, 32'd1, 32'd0, 16'h7FFF, 5'd0, 1, 0, 1, 0, 0);
    chk("R4 sext positive", alu_b, 32'h0000_7FFF);
    chk("R2 addi", alu_y, 32'h8000);
    drive(6'd10, 6'd0, 32'hFFFF_FFFF, 32'd0, 16'd1, 5'd0, 1, 0, 1, 0, 0);
    chk("R2 slti", alu_y, 32'd1);
    drive(6'd11, 6'd0, 32'hFFFF_FFFF, 32'd0, 16'd1, 5'd0, 1, 0, 1, 0, 0);
    chk("R2 sltiu", alu_y, 32'd0);
    drive(6'd12, 6'd0, 32'h0000_F0F0, 32'd0, 16'hFF0F, 5'd0, 1, 0, 1, 0, 0);
    chk("R2 andi", alu_y, 32'h0000_F000);
    drive(6'd13, 6'd0, 32'h0001_0000, 32'd0, 16'h0001, 5'd0, 1, 0, 1, 0, 0);
    chk("R2 ori", alu_y, 32'h0001_0001);
    drive(6'd14, 6'd0, 32'h0000_00FF, 32'd0, 16'h000F, 5'd0, 1, 0, 1, 0, 0);
    chk("R2 xori", alu_y, 32'h0000_00F0);

    // R1 / R10 register format
    drive(6'd0, 6'd34, 32'd5, 32'd7, 16'hFFFF, 5'd0, 0, 1, 1, 0, 0);
    chk("R1 funct op", {26'd0, alu_op}, 32'd34);
    chk("R4 rt operand", alu_b, 32'd7);
    chk("R10 sub", alu_y, 32'hFFFF_FFFE);
    chk("R5 dest rd", {27'd0, dest_idx}, 32'd19);
    chk("R9 rtype write", {31'd0, reg_we}, 32'd1);
    drive(6'd0, 6'd3, 32'd0, 32'h8000_0000, 16'd0, 5'd4, 0, 1, 1, 0, 0);
    chk("R10 sra", alu_y, 32'hF800_0000);
    drive(6'd0, 6'd2, 32'd0, 32'h8000_0000, 16'd0, 5'd4, 0, 1, 1, 0, 0);
    chk("R10 srl", alu_y, 32'h0800_0000);
    drive(6'd0, 6'd0, 32'd0, 32'h0000_0003, 16'd0, 5'd31, 0, 1, 1, 0, 0);
    chk("R10 sll", alu_y, 32'h8000_0000);
    drive(6'd0, 6'd39, 32'd0, 32'd0, 16'd0, 5'd0, 0, 1, 1, 0, 0);
    chk("R10 nor", alu_y, 32'hFFFF_FFFF);
    drive(6'd0, 6'd8, 32'd9, 32'd9, 16'd0, 5'd0, 0, 1, 0, 0, 0);
    chk("R10 other code zero", alu_y, 32'd0);

    // R6 move-if-zero
    drive(6'd0, 6'd10, 32'hABCD, 32'd0, 16'd0, 5'd0, 0, 1, 1, 0, 0);
    chk("R6 movz rt zero writes", {31'd0, reg_we}, 32'd1);
    chk("R6 movz value", alu_y, 32'hABCD);
    drive(6'd0, 6'd10, 32'hABCD, 32'd3, 16'd0, 5'd0, 0, 1, 1, 0, 0);
    chk("R6 movz rt nonzero blocked", {31'd0, reg_we}, 32'd0);
    // R7 move-if-nonzero
    drive(6'd0, 6'd11, 32'h1234, 32'd0, 16'd0, 5'd0, 0, 1, 1, 0, 0);
    chk("R7 movn rt zero blocked", {31'd0, reg_we}, 32'd0);
    drive(6'd0, 6'd11, 32'h1234, 32'h8000_0000, 16'd0, 5'd0, 0, 1, 1, 0, 0);
    chk("R7 movn rt nonzero writes", {31'd0, reg_we}, 32'd1);
    chk("R7 movn value", alu_y, 32'h1234);
    // Same funct codes on a non-register opcode do not block (R1 table path)
    drive(6'd9, 6'd10, 32'd1, 32'd5, 16'd2, 5'd0, 1, 0, 1, 0, 0);
    chk("R2 addiu ignores funct", {31'd0, reg_we}, 32'd1);
    chk("R2 addiu value", alu_y, 32'd3);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule